// File: doc/BRIEF.md
# Register-Mapped SPI Master Shift Controller

This block is an SPI bus master for a chip's register bus. Software programs a mode word that selects clock polarity, clock phase, bit order, word length and clock rate. It then writes one data word to the transmit register. The controller moves that word into its shift logic and exchanges it with the slave, one bit per SPI clock period. It then places the word captured from the slave in the receive register and raises a receive event. Events are sticky and cleared by writing ones. A mask register routes them onto a single interrupt line. Chip selects are driven outside the block.

The exchange is run by a small state machine. ST_IDLE leaves for ST_HALF_A when the controller is active and the transmit register holds a word; that transition is the hand-over into the shifter. ST_HALF_A is the half period with the clock at its rest level. When the divider tick arrives it moves to ST_HALF_B and drives the leading clock edge. ST_HALF_B is the half period with the clock in its active level. When the tick arrives it drives the trailing edge and goes back to ST_HALF_A, or goes to ST_WRAP after the last bit. ST_WRAP lasts one cycle, hands the received word to the register file and returns to ST_IDLE. From any state, clearing the enable or master bit forces ST_IDLE.

The SPI clock divider counts system clocks per half period. The count is 2 × (prescale + 1), multiplied by 16 when the extra divide stage is selected. The counter is held at zero whenever the state machine is not shifting.

Top module: `spi_shift_master`

## Requirements
- R1: Registers sit at byte offsets 0x20 mode, 0x24 event, 0x28 mask, 0x2C command, 0x30 transmit and 0x34 receive. The mode register keeps bits 29:16 and reads other bits as zero. The mask register keeps bits 9 and 8 only. The command register reads zero.
- R2: After reset the mode, mask and receive registers read zero and the event register reads 0x100. The serial clock output and irq are low.
- R3: The length code in mode bits 23:20 selects a word of code + 1 bits, and code 0 selects 32 bits. One exchange gives exactly that many clock pulses and sends the low-order bits of the transmit word. The received word is right-aligned with zeros above it.
- R4: With mode bit 26 set, bits go out and come in most significant first. With bit 26 clear they go least significant first.
- R5: Mode bit 29 sets the rest level of the serial clock. When mode bit 28 is clear, data is valid before the leading edge and is sampled on it. When bit 28 is set, data changes on the leading edge and is sampled on the trailing edge.
- R6: One serial clock period is 4 × (prescale + 1) system clocks, where prescale is mode bits 19:16. When mode bit 27 is set, the period is 16 times that.
- R7: When a word completes, the receive register holds the captured word and event bit 9 is set.
- R8: Event bit 8 clears on an accepted transmit write. It sets again when that word moves into the shifter.
- R9: Writing a one to an event bit clears it. Bits written as zero keep their value.
- R10: irq is high exactly when some event bit and the same mask bit are both set.
- R11: While mode bit 24 (enable) or bit 25 (master) is clear, transmit writes are ignored and no clock pulses occur. The serial clock rests at the level set by bit 29, and the ignored word is not sent after the block is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for addr, combinational |
| sck | output | 1 | SPI serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| irq | output | 1 | Interrupt, high while a masked-in event is pending |

## Verification
The exchange is run against a behavioural slave that shifts its own word back. Random word lengths, both bit orders, both clock polarities, both phases and several prescale settings are drawn. Comparing the receive register with the slave's word shows whether sampling happens on the correct edge, and comparing the slave's capture with the transmit word shows whether bits are launched on the correct edge. An asymmetric pattern on both sides separates most-first from least-first order. Directed cases cover the 4-bit and 32-bit ends of the length range, measured clock periods with and without the divide-by-16 stage, and the event, mask and disable behaviour.

// File: rtl/spi_mst_pkg.sv
package spi_mst_pkg;

    localparam int WORD_W = 32;
    localparam int IDX_W  = $clog2(WORD_W);

    localparam int OFF_MODE = 'h20;
    localparam int OFF_EVT  = 'h24;
    localparam int OFF_MASK = 'h28;
    localparam int OFF_CMD  = 'h2C;
    localparam int OFF_TX   = 'h30;
    localparam int OFF_RX   = 'h34;

    localparam int EV_NE_BIT = 9;
    localparam int EV_NF_BIT = 8;

    localparam int MODE_LO = 16;
    localparam int MODE_HI = 29;

    // Mode fields, most significant first: bits 29 down to 16
    typedef struct packed {
        logic       cpol;
        logic       cpha;
        logic       div16;
        logic       msb_first;
        logic       master;
        logic       enable;
        logic [3:0] len_code;
        logic [3:0] prescale;
    } mode_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HALF_A = 2'd1,
        ST_HALF_B = 2'd2,
        ST_WRAP   = 2'd3
    } xfer_state_t;

endpackage

// File: rtl/spi_mst_clkdiv.sv
module spi_mst_clkdiv #(
    parameter int PM_W     = 4,
    parameter int BASE_SH  = 1,
    parameter int EXTRA_SH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [PM_W-1:0] prescale,
    input  logic            div16,
    output logic            tick
);
    localparam int CNT_W = PM_W + 1 + BASE_SH + EXTRA_SH;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] half_len;
    logic [CNT_W-1:0] half_last;

    // Half period length in system clocks
    always_comb begin
        half_len = CNT_W'({1'b0, prescale}) + CNT_W'(1);
        if (div16) begin
            half_len = half_len << (BASE_SH + EXTRA_SH);
        end else begin
            half_len = half_len << BASE_SH;
        end
        half_last = half_len - CNT_W'(1);
    end

    assign tick = run && (cnt_q == half_last);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/spi_mst_shifter.sv
module spi_mst_shifter
    import spi_mst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  mode_t             mode,
    input  logic              tx_full,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tick,
    input  logic              miso,
    output logic              take,
    output logic              done,
    output logic              busy,
    output logic              run,
    output logic [WORD_W-1:0] rx_word,
    output logic              sck,
    output logic              mosi
);
    xfer_state_t state_q, state_d;

    logic [WORD_W-1:0] tx_q;
    logic [WORD_W-1:0] rx_q;
    logic [IDX_W-1:0]  idx_q;
    logic              sck_on_q;
    logic              mosi_q;

    logic [IDX_W-1:0]  last_idx;
    logic [IDX_W-1:0]  pos_first;
    logic [IDX_W-1:0]  pos_cur;
    logic [IDX_W-1:0]  pos_next;
    logic              is_last;
    logic              edge_lead;
    logic              edge_trail;

    // Word length decode: code 0 is the full word, otherwise code + 1 bits
    always_comb begin
        if (mode.len_code == 4'd0) begin
            last_idx = IDX_W'(WORD_W - 1);
        end else begin
            last_idx = IDX_W'(mode.len_code);
        end
        is_last = (idx_q == last_idx);
        if (mode.msb_first) begin
            pos_first = last_idx;
            pos_cur   = last_idx - idx_q;
            pos_next  = last_idx - idx_q - IDX_W'(1);
        end else begin
            pos_first = '0;
            pos_cur   = idx_q;
            pos_next  = idx_q + IDX_W'(1);
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (active && tx_full) state_d = ST_HALF_A;
            end
            ST_HALF_A: begin
                if (tick) state_d = ST_HALF_B;
            end
            ST_HALF_B: begin
                if (tick) state_d = is_last ? ST_WRAP : ST_HALF_A;
            end
            ST_WRAP: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        if (!active) state_d = ST_IDLE;
    end

    // Outputs decoded from the state
    always_comb begin
        take       = (state_q == ST_IDLE) && active && tx_full;
        done       = (state_q == ST_WRAP);
        busy       = (state_q != ST_IDLE);
        run        = (state_q == ST_HALF_A) || (state_q == ST_HALF_B);
        edge_lead  = active && (state_q == ST_HALF_A) && tick;
        edge_trail = active && (state_q == ST_HALF_B) && tick;
        sck        = mode.cpol ^ sck_on_q;
        mosi       = mosi_q;
        rx_word    = rx_q;
    end

    // Bit datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q     <= '0;
            rx_q     <= '0;
            idx_q    <= '0;
            sck_on_q <= 1'b0;
            mosi_q   <= 1'b0;
        end else if (take) begin
            tx_q     <= tx_word;
            rx_q     <= '0;
            idx_q    <= '0;
            sck_on_q <= 1'b0;
            mosi_q   <= tx_word[pos_first];
        end else if (!active) begin
            sck_on_q <= 1'b0;
        end else if (edge_lead) begin
            sck_on_q <= 1'b1;
            if (!mode.cpha) begin
                rx_q[pos_cur] <= miso;
            end else begin
                mosi_q <= tx_q[pos_cur];
            end
        end else if (edge_trail) begin
            sck_on_q <= 1'b0;
            if (mode.cpha) begin
                rx_q[pos_cur] <= miso;
            end
            if (!is_last) begin
                idx_q <= idx_q + IDX_W'(1);
                if (!mode.cpha) begin
                    mosi_q <= tx_q[pos_next];
                end
            end
        end
    end

endmodule

// File: rtl/spi_mst_regs.sv
module spi_mst_regs
    import spi_mst_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              take,
    input  logic              done,
    input  logic [WORD_W-1:0] rx_word,
    output mode_t             mode,
    output logic              active,
    output logic              tx_full,
    output logic [WORD_W-1:0] tx_word,
    output logic [1:0]        ev_flags,
    output logic [1:0]        mk_flags,
    output logic [WORD_W-1:0] rdata,
    output logic              irq
);
    logic              ev_ne_q, ev_nf_q;
    logic              mk_ne_q, mk_nf_q;
    logic [WORD_W-1:0] tx_hold_q;
    logic [WORD_W-1:0] rx_hold_q;
    logic              tx_full_q;

    logic sel_mode, sel_evt, sel_mask, sel_tx, sel_rx;
    logic tx_accept;

    always_comb begin
        sel_mode  = (addr == ADDR_W'(OFF_MODE));
        sel_evt   = (addr == ADDR_W'(OFF_EVT));
        sel_mask  = (addr == ADDR_W'(OFF_MASK));
        sel_tx    = (addr == ADDR_W'(OFF_TX));
        sel_rx    = (addr == ADDR_W'(OFF_RX));
        active    = mode.enable && mode.master;
        tx_accept = wr_en && sel_tx && active;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode      <= '0;
            ev_ne_q   <= 1'b0;
            ev_nf_q   <= 1'b1;
            mk_ne_q   <= 1'b0;
            mk_nf_q   <= 1'b0;
            tx_hold_q <= '0;
            tx_full_q <= 1'b0;
            rx_hold_q <= '0;
        end else begin
            if (wr_en && sel_mode) begin
                mode <= mode_t'(wdata[MODE_HI:MODE_LO]);
            end
            if (wr_en && sel_mask) begin
                mk_ne_q <= wdata[EV_NE_BIT];
                mk_nf_q <= wdata[EV_NF_BIT];
            end
            // A new word written in the hand-over cycle stays pending
            if (tx_accept) begin
                tx_hold_q <= wdata;
                tx_full_q <= 1'b1;
            end else if (take) begin
                tx_full_q <= 1'b0;
            end
            // Hardware set wins over a clear in the same cycle
            if (done) begin
                ev_ne_q <= 1'b1;
            end else if (wr_en && sel_evt && wdata[EV_NE_BIT]) begin
                ev_ne_q <= 1'b0;
            end
            if (tx_accept) begin
                ev_nf_q <= 1'b0;
            end else if (take) begin
                ev_nf_q <= 1'b1;
            end else if (wr_en && sel_evt && wdata[EV_NF_BIT]) begin
                ev_nf_q <= 1'b0;
            end
            if (done) begin
                rx_hold_q <= rx_word;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (sel_mode) begin
            rdata[MODE_HI:MODE_LO] = mode;
        end else if (sel_evt) begin
            rdata[EV_NE_BIT] = ev_ne_q;
            rdata[EV_NF_BIT] = ev_nf_q;
        end else if (sel_mask) begin
            rdata[EV_NE_BIT] = mk_ne_q;
            rdata[EV_NF_BIT] = mk_nf_q;
        end else if (sel_rx) begin
            rdata = rx_hold_q;
        end
    end

    assign tx_full  = tx_full_q;
    assign tx_word  = tx_hold_q;
    assign ev_flags = {ev_ne_q, ev_nf_q};
    assign mk_flags = {mk_ne_q, mk_nf_q};
    assign irq      = (ev_ne_q && mk_ne_q) || (ev_nf_q && mk_nf_q);

endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master
    import spi_mst_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int BASE_SH  = 1,
    parameter int EXTRA_SH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              irq
);
    mode_t             mode_q;
    logic              active;
    logic              tx_full;
    logic [WORD_W-1:0] tx_word;
    logic [WORD_W-1:0] rx_word;
    logic [1:0]        ev_flags;
    logic [1:0]        mk_flags;
    logic              take, done, busy, run, tick;
    logic              tx_wr_sel;

    assign tx_wr_sel = wr_en && (addr == ADDR_W'(OFF_TX));

    spi_mst_regs #(
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .take     (take),
        .done     (done),
        .rx_word  (rx_word),
        .mode     (mode_q),
        .active   (active),
        .tx_full  (tx_full),
        .tx_word  (tx_word),
        .ev_flags (ev_flags),
        .mk_flags (mk_flags),
        .rdata    (rdata),
        .irq      (irq)
    );

    spi_mst_clkdiv #(
        .PM_W     ($bits(mode_q.prescale)),
        .BASE_SH  (BASE_SH),
        .EXTRA_SH (EXTRA_SH)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .prescale (mode_q.prescale),
        .div16    (mode_q.div16),
        .tick     (tick)
    );

    spi_mst_shifter u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .mode    (mode_q),
        .tx_full (tx_full),
        .tx_word (tx_word),
        .tick    (tick),
        .miso    (miso),
        .take    (take),
        .done    (done),
        .busy    (busy),
        .run     (run),
        .rx_word (rx_word),
        .sck     (sck),
        .mosi    (mosi)
    );

endmodule

// File: rtl/spi_mst_checker.sv
module spi_mst_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       active,
    input logic       cpol,
    input logic       sck,
    input logic       busy,
    input logic       done,
    input logic       tx_full,
    input logic       tx_wr,
    input logic [1:0] ev,
    input logic [1:0] mk,
    input logic       irq
);
    // R11: with the controller inactive the clock rests at its idle level
    p_idle_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && $past(!active)) |-> (sck == cpol));

    // R11: a transmit write while inactive leaves the holding register empty
    p_ignored_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && !active && !tx_full) |=> !tx_full);

    // R7: the receive event only rises after a word has completed
    p_ne_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ev[1]) |-> $past(done));

    // R8: the hand-over into the shifter reports the holding register free
    p_nf_on_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_full) |-> ev[0]);

    // R5: the clock only moves while a word is shifting or the polarity changes
    p_sck_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && $stable(cpol)) |-> $stable(sck));

    // R10: with every mask bit clear the interrupt stays low
    p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mk == 2'b00) |-> !irq);

endmodule

bind spi_shift_master spi_mst_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (active),
    .cpol    (mode_q.cpol),
    .sck     (sck),
    .busy    (busy),
    .done    (done),
    .tx_full (tx_full),
    .tx_wr   (tx_wr_sel),
    .ev      (ev_flags),
    .mk      (mk_flags),
    .irq     (irq)
);

// File: tb/sim_spi_shift_master.sv
`timescale 1ns/1ps
module sim_spi_shift_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic        sck, mosi, irq;
    logic        miso = 1'b0;

    int n_chk = 0;
    int n_err = 0;

    // Slave model state
    logic [31:0] s_word = 32'h0;
    logic [31:0] s_cap = 32'h0;
    int          s_len = 8;
    logic        s_cpol = 1'b0;
    logic        s_cpha = 1'b0;
    logic        s_msb = 1'b1;
    int          out_cnt = 0;
    int          in_cnt = 0;
    int          lead_cnt = 0;
    realtime     t_lead0 = 0.0;
    realtime     t_lead1 = 0.0;

    always #2.5 clk = ~clk;

    spi_shift_master u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .sck   (sck),
        .mosi  (mosi),
        .miso  (miso),
        .irq   (irq)
    );

    function automatic int spos(input int k);
        return s_msb ? (s_len - 1 - k) : k;
    endfunction

    function automatic int len_of(input logic [3:0] code);
        return (code == 4'd0) ? 32 : int'(code) + 1;
    endfunction

    function automatic logic [31:0] len_mask(input int len);
        return (len == 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 32'h1);
    endfunction

    // Behavioural slave: samples and launches on the edges the phase selects
    always @(posedge sck or negedge sck) begin
        if (sck != s_cpol) begin
            lead_cnt = lead_cnt + 1;
            if (lead_cnt == 1) t_lead0 = $realtime;
            if (lead_cnt == 2) t_lead1 = $realtime;
            if (!s_cpha) begin
                if (in_cnt < s_len) s_cap[spos(in_cnt)] = mosi;
                in_cnt = in_cnt + 1;
            end else begin
                if (out_cnt < s_len) miso = s_word[spos(out_cnt)];
                out_cnt = out_cnt + 1;
            end
        end else begin
            if (!s_cpha) begin
                out_cnt = out_cnt + 1;
                if (out_cnt < s_len) miso = s_word[spos(out_cnt)];
            end else begin
                if (in_cnt < s_len) s_cap[spos(in_cnt)] = mosi;
                in_cnt = in_cnt + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic slave_reset(input logic cpol, input logic cpha, input logic msb,
                               input int len, input logic [31:0] sw);
        s_cpol = cpol; s_cpha = cpha; s_msb = msb; s_len = len; s_word = sw;
        s_cap = 32'h0; out_cnt = 0; in_cnt = 0; lead_cnt = 0;
        miso = cpha ? 1'b0 : sw[spos(0)];
    endtask

    // One exchange; three checks against values derived from the requirements
    task automatic xfer(input logic [3:0] code, input logic cpol, input logic cpha,
                        input logic msb, input logic [3:0] pm, input logic div16,
                        input logic [31:0] txw, input logic [31:0] sw, input string tag);
        logic [31:0] d;
        logic got;
        int len;
        len = len_of(code);
        wr(8'h20, {2'b00, cpol, cpha, div16, msb, 1'b1, 1'b1, code, pm, 16'h0});
        slave_reset(cpol, cpha, msb, len, sw);
        wr(8'h24, 32'h300);
        wr(8'h30, txw);
        got = 1'b0;
        for (int i = 0; i < 6000 && !got; i++) begin
            @(negedge clk);
            rd(8'h24, d);
            got = d[9];
        end
        chk({tag, " R7 completion event"}, {31'h0, got}, 32'h1);
        rd(8'h34, d);
        chk({tag, " R3 R4 R5 receive word"}, d, sw & len_mask(len));
        chk({tag, " R3 R4 R5 slave capture"}, s_cap, txw & len_mask(len));
        chk({tag, " R3 pulse count"}, 32'(lead_cnt), 32'(len));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int seed;
        seed = 20240611;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        rd(8'h20, d); chk("R2 mode reset", d, 32'h0);
        rd(8'h24, d); chk("R2 event reset", d, 32'h100);
        rd(8'h28, d); chk("R2 mask reset", d, 32'h0);
        rd(8'h34, d); chk("R2 receive reset", d, 32'h0);
        chk("R2 sck reset", {31'h0, sck}, 32'h0);
        chk("R2 irq reset", {31'h0, irq}, 32'h0);

        // R1 register map and readback
        rd(8'h2C, d); chk("R1 command reads zero", d, 32'h0);
        wr(8'h28, 32'hFFFF_FFFF);
        rd(8'h28, d); chk("R1 mask keeps bits 9:8", d, 32'h300);
        wr(8'h28, 32'h0);
        wr(8'h20, 32'hC0AB_0000);
        rd(8'h20, d); chk("R1 mode keeps bits 29:16", d, 32'h00AB_0000);
        wr(8'h20, 32'h3CAB_0000);
        rd(8'h20, d); chk("R1 mode readback", d, 32'h3CAB_0000);

        // R11 writes ignored while disabled or not master
        wr(8'h20, 32'h2207_0000);
        slave_reset(1'b1, 1'b0, 1'b1, 8, 32'h0);
        chk("R11 idle level high", {31'h0, sck}, 32'h1);
        wr(8'h24, 32'h300);
        wr(8'h30, 32'h0000_00A5);
        repeat (64) @(negedge clk);
        chk("R11 no pulses when disabled", 32'(lead_cnt), 32'h0);
        rd(8'h24, d); chk("R11 no event when disabled", d, 32'h0);
        wr(8'h20, 32'h2107_0000);
        wr(8'h30, 32'h0000_005A);
        repeat (64) @(negedge clk);
        chk("R11 no pulses without master", 32'(lead_cnt), 32'h0);
        wr(8'h20, 32'h2307_0000);
        repeat (64) @(negedge clk);
        chk("R11 ignored word not sent", 32'(lead_cnt), 32'h0);
        rd(8'h24, d); chk("R11 events still clear", d, 32'h0);
        rd(8'h34, d); chk("R11 receive unchanged", d, 32'h0);

        // Directed exchanges at the length bounds and phase corners
        xfer(4'd0, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0, 32'h8000_0001, 32'hC3A5_0F1E, "32b msb mode0");
        xfer(4'd0, 1'b1, 1'b1, 1'b0, 4'd1, 1'b0, 32'h1234_5678, 32'h8000_0003, "32b lsb mode3");
        xfer(4'd3, 1'b1, 1'b1, 1'b0, 4'd15, 1'b0, 32'hFFFF_FFF6, 32'hFFFF_FFF9, "4b lsb");
        chk("R6 period prescale 15", 32'(int'((t_lead1 - t_lead0) / 5.0)), 32'd64);
        xfer(4'd15, 1'b0, 1'b1, 1'b1, 4'd0, 1'b0, 32'h0000_B00D, 32'h0000_6E71, "16b msb mode1");
        xfer(4'd7, 1'b1, 1'b0, 1'b0, 4'd2, 1'b0, 32'h0000_00C1, 32'h0000_0083, "8b lsb mode2");
        chk("R6 period prescale 2", 32'(int'((t_lead1 - t_lead0) / 5.0)), 32'd12);
        xfer(4'd4, 1'b0, 1'b0, 1'b1, 4'd1, 1'b1, 32'h0000_0013, 32'h0000_000D, "5b div16");
        chk("R6 period with divide-by-16", 32'(int'((t_lead1 - t_lead0) / 5.0)), 32'd128);

        // R8 not-full event around a transmit write
        wr(8'h24, 32'h300);
        rd(8'h24, d); chk("R8 events cleared", d, 32'h0);
        slave_reset(1'b0, 1'b0, 1'b1, 5, 32'h0);
        wr(8'h24, 32'h0);
        wr(8'h30, 32'h0000_0011);
        rd(8'h24, d); chk("R8 cleared by transmit write", d, 32'h0);
        @(negedge clk);
        rd(8'h24, d); chk("R8 set when word enters shifter", d, 32'h100);
        repeat (800) @(negedge clk);
        rd(8'h24, d); chk("R7 both events after completion", d, 32'h300);

        // R9 write-one-to-clear
        wr(8'h24, 32'h200);
        rd(8'h24, d); chk("R9 clear receive event only", d, 32'h100);
        wr(8'h24, 32'h0);
        rd(8'h24, d); chk("R9 zero write keeps bits", d, 32'h100);
        wr(8'h24, 32'h100);
        rd(8'h24, d); chk("R9 clear not-full event", d, 32'h0);

        // R10 interrupt from masked events
        xfer(4'd7, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0, 32'h0000_003C, 32'h0000_00E7, "irq setup");
        chk("R10 irq low with mask clear", {31'h0, irq}, 32'h0);
        wr(8'h24, 32'h100);
        wr(8'h28, 32'h100);
        chk("R10 irq low for unset event", {31'h0, irq}, 32'h0);
        wr(8'h28, 32'h200);
        chk("R10 irq high for masked event", {31'h0, irq}, 32'h1);
        wr(8'h24, 32'h200);
        chk("R10 irq low after clear", {31'h0, irq}, 32'h0);
        wr(8'h28, 32'h0);

        // Random exchanges across lengths, orders, polarities, phases and rates
        for (int n = 0; n < 40; n++) begin
            logic [3:0] code;
            logic [3:0] pm;
            logic dv;
            int pick;
            pick = int'($urandom % 14);
            code = (pick == 0) ? 4'd0 : 4'(pick + 2);
            dv = (($urandom % 8) == 0);
            pm = dv ? 4'd0 : 4'($urandom % 3);
            if (dv && code == 4'd0) code = 4'd7;
            xfer(code, 1'($urandom), 1'($urandom), 1'($urandom), pm, dv,
                 $urandom, $urandom, "random");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule